// File: doc/BRIEF.md
# Branch Condition and Set-on-Flag Evaluator

This block turns a 4-bit condition selector and a five-flag status word into one true/false bit. The flags are zero, sign, carry, overflow and a sticky saturation flag. The same bit has two uses. A conditional branch uses it to decide whether it is taken. A set-on-flag operation uses it as the value written to its destination register.

The selector covers three groups of tests: single-flag tests, unsigned and signed comparisons built from flag combinations, and the inverse of each. One code always holds. One code tests the saturation flag on its own.

Next to the evaluator sits a small target stage. When the condition holds, it adds a sign-extended branch displacement to the current program counter. When it does not, it steps the counter past the 2-byte instruction. The whole block is combinational and has no clock or reset.

Top module: `cc_branch_eval`

## Requirements
- R1: The status word is packed with zero in bit 0, sign in bit 1, carry in bit 2, overflow in bit 3 and saturation in bit 4. Selector values 0, 1, 2, 3 and 4 are true when, respectively, overflow is 1, carry is 1, zero is 1, (carry OR zero) is 1, and sign is 1.
- R2: Selector value 5 is true for every status word.
- R3: Selector value 6 is true when sign XOR overflow is 1 (signed less-than). Selector value 7 is true when (sign XOR overflow) OR zero is 1 (signed less-or-equal).
- R4: Selector values 8 to 12 are the exact inverses of values 0 to 4.
- R5: Selector value 13 is true exactly when the saturation bit is 1.
- R6: Selector value 14 is the inverse of value 6, and selector value 15 is the inverse of value 7.
- R7: The set-on-flag word is 1 when the condition holds and 0 otherwise. All bits above bit 0 are always 0.
- R8: When the condition holds, the next program counter is the current one plus the 9-bit displacement sign-extended to the address width, with the sum wrapping modulo 2^32.
- R9: When the condition does not hold, the next program counter is the current one plus 2.
- R10: The saturation bit has no effect on any selector value other than 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_sel | input | 4 | Condition selector, values 0 to 15 |
| status | input | 5 | Flags: bit0 zero, bit1 sign, bit2 carry, bit3 overflow, bit4 saturation |
| pc | input | 32 | Address of the current instruction |
| disp | input | 9 | Signed branch displacement |
| cond_true | output | 1 | Selected condition holds; this is the branch-taken indication |
| setf_word | output | 32 | Set-on-flag result, 0 or 1 |
| next_pc | output | 32 | Branch target if taken, otherwise pc + 2 |

## Verification
The bench builds the block with its default parameters: a 32-bit data word and address, a 9-bit displacement and a 2-byte step. With only 4 selector bits and 5 flag bits, all 512 selector/flag combinations are applied. This covers every condition, and it also shows that the saturation bit cannot leak into any code other than 13. All 512 displacement values are then applied with program counters near zero, in the middle of the range and near the top. Each is run once with the condition forced true and once forced false, which exercises sign extension, wrap-around and the fall-through step.

// File: rtl/cc_pkg.sv
// Shared definitions for the branch condition evaluator.
// It assumes a status word of five flags, with zero in the least significant bit.
package cc_pkg;

    // Flag packing. Struct order puts zero at bit 0 and saturation at bit 4.
    typedef struct packed {
        logic sat;
        logic ov;
        logic cy;
        logic s;
        logic z;
    } cc_flags_t;

    // Selector codes. The encoding is fixed because the upper half inverts the lower half.
    typedef enum logic [3:0] {
        CC_OVF      = 4'd0,
        CC_CARRY    = 4'd1,
        CC_ZERO     = 4'd2,
        CC_ULE      = 4'd3,
        CC_NEG      = 4'd4,
        CC_ALWAYS   = 4'd5,
        CC_SLT      = 4'd6,
        CC_SLE      = 4'd7,
        CC_NOVF     = 4'd8,
        CC_NCARRY   = 4'd9,
        CC_NZERO    = 4'd10,
        CC_UGT      = 4'd11,
        CC_POS      = 4'd12,
        CC_SATUR    = 4'd13,
        CC_SGE      = 4'd14,
        CC_SGT      = 4'd15
    } cc_code_e;

endpackage

// File: rtl/cc_cond_eval.sv
// Condition evaluator.
// Builds all sixteen condition values from the flags and picks the selected one.
// Codes 8..15 invert codes 0..7, except that code 13 tests saturation instead.
// It assumes the selector and flags are stable within a cycle; it is pure logic.
module cc_cond_eval
    import cc_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic [SEL_W-1:0] sel,
    input  cc_flags_t        flags,
    output logic             hold
);

    localparam int NCODE = 1 << SEL_W;
    localparam int HALF  = NCODE / 2;

    logic [HALF-1:0]  base;
    logic [NCODE-1:0] cond_vec;

    // Derive the eight basic conditions of the lower half.
    always_comb begin
        base[0] = flags.ov;
        base[1] = flags.cy;
        base[2] = flags.z;
        base[3] = flags.cy | flags.z;
        base[4] = flags.s;
        base[5] = 1'b1;
        base[6] = flags.s ^ flags.ov;
        base[7] = (flags.s ^ flags.ov) | flags.z;
    end

    // Expand to sixteen: the lower half passes through, the upper half inverts, slot 13 takes saturation.
    for (genvar i = 0; i < NCODE; i++) begin : g_code
        if (i == int'(CC_SATUR)) begin : g_sat
            assign cond_vec[i] = flags.sat;
        end else if (i < HALF) begin : g_pos
            assign cond_vec[i] = base[i];
        end else begin : g_neg
            assign cond_vec[i] = ~base[i-HALF];
        end
    end

    // Select the requested condition.
    assign hold = cond_vec[sel];

    // Check the pairing and the special codes against the selected output.
    always_comb begin
        if (sel >= SEL_W'(HALF) && sel != SEL_W'(CC_SATUR)) begin
            assert_pair_inverse_R4: assert (hold != base[sel[SEL_W-2:0]])
                else $error("upper code does not invert its partner");
        end
        if (sel == SEL_W'(CC_ALWAYS)) begin
            assert_always_true_R2: assert (hold)
                else $error("always code returned false");
        end
        if (sel == SEL_W'(CC_SATUR)) begin
            assert_sat_only_R5: assert (hold == flags.sat)
                else $error("saturation code mismatch");
        end
    end

endmodule

// File: rtl/cc_target.sv
// Next program counter stage.
// Sign-extends the displacement and adds it to pc when taken; otherwise adds the fixed step.
// It assumes the displacement is narrower than the address.
module cc_target #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 9,
    parameter int STEP   = 2
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    input  logic              taken,
    output logic [ADDR_W-1:0] target
);

    localparam int          EXT_W   = ADDR_W - DISP_W;
    localparam [ADDR_W-1:0] STEP_AW = ADDR_W'(STEP);

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] delta;

    // Replicate the displacement sign bit up to the address width.
    assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};

    // Choose the increment, then do a single add.
    always_comb begin
        delta  = taken ? disp_ext : STEP_AW;
        target = pc + delta;
    end

    // Check the fall-through step and the direction of a taken branch.
    always_comb begin
        if (!taken) begin
            assert_step_R9: assert (target - pc == STEP_AW)
                else $error("fall-through step wrong");
        end else begin
            assert_disp_sign_R8: assert ((target - pc) >> (DISP_W - 1) ==
                                         (disp[DISP_W-1] ? {ADDR_W{1'b1}} >> (DISP_W - 1) : '0))
                else $error("taken offset not sign-extended");
        end
    end

endmodule

// File: rtl/cc_branch_eval.sv
// Top level: the condition evaluator, the set-on-flag word and the next pc.
// One condition bit feeds both the branch decision and the register write value.
// It assumes DATA_W >= 2 and ADDR_W > DISP_W. Purely combinational.
module cc_branch_eval
    import cc_pkg::*;
#(
    parameter int SEL_W  = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int DISP_W = 9,
    parameter int STEP   = 2
) (
    input  logic [SEL_W-1:0]  cond_sel,
    input  logic [4:0]        status,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    output logic              cond_true,
    output logic [DATA_W-1:0] setf_word,
    output logic [ADDR_W-1:0] next_pc
);

    cc_flags_t flags;

    // Reinterpret the raw status bits as named flags.
    assign flags = cc_flags_t'(status);

    cc_cond_eval #(.SEL_W(SEL_W)) u_eval (
        .sel   (cond_sel),
        .flags (flags),
        .hold  (cond_true)
    );

    // Zero-extend the condition into the destination word.
    assign setf_word = {{(DATA_W-1){1'b0}}, cond_true};

    cc_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .STEP(STEP)) u_tgt (
        .pc     (pc),
        .disp   (disp),
        .taken  (cond_true),
        .target (next_pc)
    );

    // The register value and the branch decision agree, and the upper bits stay clear.
    always_comb begin
        assert_setf_binary_R7: assert (setf_word[DATA_W-1:1] == '0 && setf_word[0] == cond_true)
            else $error("set-on-flag word not 0/1");
    end

endmodule

// File: tb/sim_cc_branch_eval.sv
`timescale 1ns/1ps
module sim_cc_branch_eval;

    logic        clk = 1'b0;
    logic [3:0]  cond_sel;
    logic [4:0]  status;
    logic [31:0] pc;
    logic [8:0]  disp;
    logic        cond_true;
    logic [31:0] setf_word;
    logic [31:0] next_pc;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cc_branch_eval u0 (
        .cond_sel  (cond_sel),
        .status    (status),
        .pc        (pc),
        .disp      (disp),
        .cond_true (cond_true),
        .setf_word (setf_word),
        .next_pc   (next_pc)
    );

    // Reference: z=bit0, s=bit1, cy=bit2, ov=bit3, sat=bit4.
    function automatic bit ref_cond(input int code, input logic [4:0] st);
        bit z = st[0], s = st[1], cy = st[2], ov = st[3], sat = st[4];
        bit lt = (s != ov);
        case (code)
            0:  return ov;
            1:  return cy;
            2:  return z;
            3:  return cy || z;
            4:  return s;
            5:  return 1;
            6:  return lt;
            7:  return lt || z;
            8:  return !ov;
            9:  return !cy;
            10: return !z;
            11: return !(cy || z);
            12: return !s;
            13: return sat;
            14: return !lt;
            default: return !(lt || z);
        endcase
    endfunction

    function automatic string req_of(input int code);
        if (code <= 4) return "R1";
        if (code == 5) return "R2";
        if (code <= 7) return "R3";
        if (code <= 12) return "R4";
        if (code == 13) return "R5";
        return "R6";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            finish_run();
        end
    end

    initial begin
        cond_sel = 4'd0; status = 5'd0; pc = 32'd0; disp = 9'd0;
        @(negedge clk);
        // Idle state with all-zero inputs: no branch, step of 2 (R9)
        check("R1", {31'd0, cond_true}, 32'd0);
        check("R9", next_pc, 32'd2);

        // Exhaustive selector x flags sweep (R1-R6 per code, R7 word, R10 sat independence)
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 32; f++) begin
                @(posedge clk);
                cond_sel = 4'(c); status = 5'(f); pc = 32'h0000_1000; disp = 9'd4;
                @(negedge clk);
                check(req_of(c), {31'd0, cond_true}, {31'd0, ref_cond(c, 5'(f))});
                check("R7", setf_word, {31'd0, ref_cond(c, 5'(f))});
                if (c != 13 && f >= 16) begin
                    // R10: flipping sat alone leaves the result unchanged
                    check("R10", {31'd0, cond_true}, {31'd0, ref_cond(c, 5'(f - 16))});
                end
            end
        end

        // Target sweep: all displacements, three pcs, taken and not taken
        for (int p = 0; p < 3; p++) begin
            for (int d = 0; d < 512; d++) begin
                logic [31:0] base_pc;
                int off;
                base_pc = (p == 0) ? 32'h0000_0010 : (p == 1) ? 32'h4000_0000 : 32'hFFFF_FFF0;
                off = (d >= 256) ? d - 512 : d;
                @(posedge clk);
                pc = base_pc; disp = 9'(d); cond_sel = 4'd5; status = 5'd0;
                @(negedge clk);
                check("R8", next_pc, base_pc + 32'(off));
                @(posedge clk);
                cond_sel = 4'd2; status = 5'b10000;
                @(negedge clk);
                check("R9", next_pc, base_pc + 32'd2);
            end
        end

        finish_run();
    end

endmodule